// File: doc/BRIEF.md
# Fault-Triggered Output Tristate Controller

This block sits between a motor-drive timer and its output pads and shuts the pads off when something goes wrong. It has a parameterised number of channels, two by default. Each channel guards a group of timer output enables. It watches one external fault input per channel through a two-flop synchronizer. When the chosen transition arrives on that input, or software forces a trip, the channel latches a status flag. While the flag is set, the channel pulls every output enable of its group low, so the pads float at high impedance.

Software drives each channel through an 8-bit control/status byte written over a simple strobe port and read back through a combinational select.

The fault polarity and the release policy can only be changed while the channel is disabled. A fault level that is already present when the channel is enabled does not trip it; only a fresh transition does. The release policy decides whether a software clear is honoured while the fault input still sits at its abnormal level.

Top module: `fault_tristate_ctl`

## Requirements
- R1: After reset every channel byte reads 0x00, `out_en` is all ones and `pin_oe` equals `tmr_oe`.
- R2: The channel byte reads back as bit 7 enable, bit 6 release policy, bits 5:4 fault edge (01 rising, 10 falling), bit 0 flag. Bits 3, 2 and 1 always read 0, and while the channel is disabled, bits 7:4 take the written value.
- R3: With the channel enabled, the selected transition on its fault input sets the flag by the third rising clock edge after the input changes. From then on, the channel's `out_en` bit is low and its whole `pin_oe` group is 0, while other channels are unaffected.
- R4: While the channel is enabled, writes to bits 6:4 leave them unchanged.
- R5: Writing 1 to bit 2 sets the flag only if the channel was already enabled before that write; otherwise it has no effect.
- R6: With policy 0, writing 1 to bit 1 clears the flag whatever the fault input level, and restores the outputs.
- R7: With policy 1, a clear is ignored while the synchronized fault input sits at its active level (high for edge 01, low for edge 10). It is accepted once the input has returned to the inactive level.
- R8: A fault level already present when the enable is set, and a transition in the direction not selected, never set the flag.
- R9: `fault_pulse` of a channel is high for exactly the one cycle in which its flag goes from 0 to 1.
- R10: Writing 0 to bit 7 clears the flag and restores the outputs. Bits 6:4 keep their old value in that write, because the channel was still enabled.
- R11: With edge select 00 or 11, the fault input never sets the flag.
- R12: When a fault transition and an allowed clear land in the same cycle, the flag stays 1 and no new pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one channel byte |
| wr_ch | input | CW | Channel addressed by the write |
| wr_data | input | 8 | Byte written |
| rd_ch | input | CW | Channel shown on `rd_data` |
| rd_data | output | 8 | Channel byte read back |
| fault_in | input | NCH | Asynchronous fault input per channel |
| tmr_oe | input | NCH*GRP_W | Output enables from the timer |
| pin_oe | output | NCH*GRP_W | Gated output enables to the pads |
| out_en | output | NCH | Per-channel output permission, low while tripped |
| fault_pulse | output | NCH | One-cycle pulse when a channel trips |

## Verification
The hardest case to reach is the contention in R12, where a fault transition must cross the synchronizer and land in the same cycle as a software clear. The stimulus raises the fault input just after one clock edge. It then waits two edges, so the transition reaches the edge detector, and holds the clear write across the third edge. The policy-1 release in R7 is also hard, since the input level has to be held at its abnormal level and then moved back before the clear is repeated. The pre-existing level case in R8 needs the level set up before enabling the channel, which is done by ordering the writes against the input changes.

// File: rtl/fault_tristate_ctl.sv
module fault_tristate_ctl #(
  parameter int NCH   = 2,
  parameter int GRP_W = 6,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [CW-1:0]        wr_ch,
  input  logic [7:0]           wr_data,
  input  logic [CW-1:0]        rd_ch,
  output logic [7:0]           rd_data,
  input  logic [NCH-1:0]       fault_in,
  input  logic [NCH*GRP_W-1:0] tmr_oe,
  output logic [NCH*GRP_W-1:0] pin_oe,
  output logic [NCH-1:0]       out_en,
  output logic [NCH-1:0]       fault_pulse
);

  logic [NCH-1:0]      en_q, mode_q, flag_q, s1_q, s2_q, prev_q, pulse_q;
  logic [NCH-1:0][1:0] edge_q;
  logic [NCH-1:0]      wr_hit, pin_act, edge_hit, set_req, clr_ok, en_d, flag_d;
  logic                unused_bits;

  assign unused_bits = ^{wr_data[3], wr_data[0]};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign wr_hit[g]  = wr_en && (wr_ch == CW'(g));

    assign pin_act[g] = (edge_q[g] == 2'b01) ?  s2_q[g] :
                        (edge_q[g] == 2'b10) ? !s2_q[g] : 1'b0;

    assign edge_hit[g] = en_q[g] &&
                         (((edge_q[g] == 2'b01) &&  s2_q[g] && !prev_q[g]) ||
                          ((edge_q[g] == 2'b10) && !s2_q[g] &&  prev_q[g]));

    assign set_req[g] = edge_hit[g] || (wr_hit[g] && en_q[g] && wr_data[2]);
    assign clr_ok[g]  = wr_hit[g] && wr_data[1] && (!mode_q[g] || !pin_act[g]);
    assign en_d[g]    = wr_hit[g] ? wr_data[7] : en_q[g];

    assign flag_d[g]  = !en_d[g]   ? 1'b0 :
                        set_req[g] ? 1'b1 :
                        clr_ok[g]  ? 1'b0 : flag_q[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q[g]    <= 1'b0;
        s2_q[g]    <= 1'b0;
        prev_q[g]  <= 1'b0;
        en_q[g]    <= 1'b0;
        mode_q[g]  <= 1'b0;
        edge_q[g]  <= 2'b00;
        flag_q[g]  <= 1'b0;
        pulse_q[g] <= 1'b0;
      end else begin
        s1_q[g]    <= fault_in[g];
        s2_q[g]    <= s1_q[g];
        prev_q[g]  <= s2_q[g];
        en_q[g]    <= en_d[g];
        if (wr_hit[g] && !en_q[g]) begin
          mode_q[g] <= wr_data[6];
          edge_q[g] <= wr_data[5:4];
        end
        flag_q[g]  <= flag_d[g];
        pulse_q[g] <= flag_d[g] && !flag_q[g];
      end
    end

    assign out_en[g] = !(en_q[g] && flag_q[g]);
    assign pin_oe[g*GRP_W +: GRP_W] = tmr_oe[g*GRP_W +: GRP_W] & {GRP_W{out_en[g]}};
  end

  assign fault_pulse = pulse_q;
  assign rd_data = {en_q[rd_ch], mode_q[rd_ch], edge_q[rd_ch], 3'b000, flag_q[rd_ch]};

endmodule

// File: rtl/fault_tristate_ctl_chk.sv
module fault_tristate_ctl_chk #(
  parameter int NCH = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       en_q,
  input logic [NCH-1:0]       mode_q,
  input logic [NCH-1:0][1:0]  edge_q,
  input logic [NCH-1:0]       flag_q,
  input logic [NCH-1:0]       fault_pulse
);

  for (genvar g = 0; g < NCH; g++) begin : g_a
    a_r4_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q[g]) |-> $stable(mode_q[g]));

    a_r4_edge_locked: assert property (@(posedge clk) disable iff (!rst_n)
      $past(en_q[g]) |-> $stable(edge_q[g]));

    a_r10_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |-> !flag_q[g]);

    a_r8_no_trip_at_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_q[g]) |-> !flag_q[g]);

    a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse[g] |-> (flag_q[g] && !$past(flag_q[g])));

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      fault_pulse[g] |=> !fault_pulse[g]);
  end

endmodule

bind fault_tristate_ctl fault_tristate_ctl_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_q        (en_q),
  .mode_q      (mode_q),
  .edge_q      (edge_q),
  .flag_q      (flag_q),
  .fault_pulse (fault_pulse)
);

// File: tb/sim_fault_tristate_ctl.sv
module sim_fault_tristate_ctl;
  localparam int PERIOD = 10;
  localparam int NCH = 2;
  localparam int GW  = 6;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [0:0]    wr_ch = 0;
  logic [7:0]    wr_data = 0;
  logic [0:0]    rd_ch = 0;
  logic [7:0]    rd_data;
  logic [NCH-1:0] fault_in = 0;
  logic [NCH*GW-1:0] tmr_oe = '1;
  logic [NCH*GW-1:0] pin_oe;
  logic [NCH-1:0] out_en, fault_pulse;

  int n_chk = 0, n_fail = 0;
  int pcnt [NCH];

  typedef struct { int ch; logic [7:0] reg_v; logic oe; string tag; } item_t;
  item_t q[$];

  always #(PERIOD/2) clk = ~clk;

  fault_tristate_ctl #(.NCH(NCH), .GRP_W(GW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_ch(rd_ch), .rd_data(rd_data), .fault_in(fault_in), .tmr_oe(tmr_oe),
    .pin_oe(pin_oe), .out_en(out_en), .fault_pulse(fault_pulse));

  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) if (rst_n && fault_pulse[c]) pcnt[c]++;
  end

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [GW-1:0] grp;
      it = q.pop_front();
      grp = pin_oe[it.ch*GW +: GW];
      n_chk++;
      if (rd_data !== it.reg_v || out_en[it.ch] !== it.oe || grp !== {GW{it.oe}}) begin
        n_fail++;
        $display("FAIL %s ch%0d: reg=%02h oe=%b grp=%b expected reg=%02h oe=%b",
                 it.tag, it.ch, rd_data, out_en[it.ch], grp, it.reg_v, it.oe);
      end
    end
  end

  task automatic wr(input int ch, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1; wr_ch = ch[0:0]; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic chk(input int ch, input logic [7:0] v, input logic oe, input string tag);
    item_t it;
    @(posedge clk); #1;
    rd_ch = ch[0:0];
    it.ch = ch; it.reg_v = v; it.oe = oe; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_pulse(input int ch, input int exp, input string tag);
    n_chk++;
    if (pcnt[ch] != exp) begin
      n_fail++;
      $display("FAIL %s pulse count ch%0d: got %0d expected %0d", tag, ch, pcnt[ch], exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(PERIOD*200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    pcnt[0] = 0; pcnt[1] = 0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1;
    chk(0, 8'h00, 1, "R1");
    chk(1, 8'h00, 1, "R1");

    wr(0, 8'h04);                 chk(0, 8'h00, 1, "R5 set while disabled");
    chk_pulse(0, 0, "R5");
    wr(0, 8'h90);                 chk(0, 8'h90, 1, "R2");

    fault_in[0] = 1; settle();    chk(0, 8'h91, 0, "R3 rising trip");
    chk_pulse(0, 1, "R9");
    chk(1, 8'h00, 1, "R3 other channel");
    wr(0, 8'hA0);                 chk(0, 8'h91, 0, "R4 locked fields");
    wr(0, 8'h92);                 chk(0, 8'h90, 1, "R6 clear policy0");
    fault_in[0] = 0; settle();    chk(0, 8'h90, 1, "R8 wrong direction");

    wr(1, 8'h20);                 chk(1, 8'h20, 1, "R2 disabled write");
    wr(1, 8'hA0); settle();       chk(1, 8'hA0, 1, "R8 level at enable");
    fault_in[1] = 1; settle();    chk(1, 8'hA0, 1, "R8 rising not selected");
    fault_in[1] = 0; settle();    chk(1, 8'hA1, 0, "R3 falling trip");
    chk(0, 8'h90, 1, "R3 other channel");
    wr(1, 8'h00);                 chk(1, 8'h20, 1, "R10 disable clears");

    wr(1, 8'h60);                 chk(1, 8'h60, 1, "R2 policy write");
    wr(1, 8'hE0); settle();       chk(1, 8'hE0, 1, "R8 level at enable");
    wr(1, 8'hE4);                 chk(1, 8'hE1, 0, "R5 software set");
    wr(1, 8'hE2);                 chk(1, 8'hE1, 0, "R7 clear blocked");
    fault_in[1] = 1; settle();    chk(1, 8'hE1, 0, "R7 still set");
    wr(1, 8'hE2);                 chk(1, 8'hE0, 1, "R7 clear accepted");
    chk_pulse(1, 2, "R9");

    wr(0, 8'h00);                 chk(0, 8'h10, 1, "R10 fields kept");
    wr(0, 8'h30);
    wr(0, 8'hB0);
    fault_in[0] = 1; settle();
    fault_in[0] = 0; settle();    chk(0, 8'hB0, 1, "R11 edge 11");
    wr(0, 8'h00);
    wr(0, 8'h00);
    wr(0, 8'h80);
    fault_in[0] = 1; settle();
    fault_in[0] = 0; settle();    chk(0, 8'h80, 1, "R11 edge 00");

    wr(0, 8'h00);
    wr(0, 8'h10);
    wr(0, 8'h90);
    wr(0, 8'h94);                 chk(0, 8'h91, 0, "R5 software set");
    chk_pulse(0, 2, "R9");
    @(posedge clk); #1;
    fault_in[0] = 1;
    @(posedge clk);
    @(posedge clk); #1;
    wr_en = 1; wr_ch = 0; wr_data = 8'h92;
    @(posedge clk); #1;
    wr_en = 0;
    chk(0, 8'h91, 0, "R12 set beats clear");
    chk_pulse(0, 2, "R12");

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule